// File: doc/BRIEF.md
# Rate-Coded Spike Train Encoder

This block turns a vector of unsigned channel intensities into binary spike trains for a spiking network. When a load strobe is accepted, the block captures the intensities and adds them up. For each channel it then works out how many spikes the channel gets from a fixed total budget: the budget is scaled by that channel's fraction of the total, and the result is rounded to the nearest integer. A small sequential divider does this work one channel at a time, during a setup phase.

After setup, an encoding window of a fixed number of time slots begins, one slot per clock. In every slot each channel decides whether to fire, using selection sampling driven by its own pseudo-random generator. Each channel therefore emits exactly its allotted number of spikes, spread over the window rather than packed at its start. The cycle after the last slot carries a one-cycle done pulse, and the block then accepts the next load.

Top module: `spike_train_encoder`

## Requirements
- R1: While reset is asserted and right after it, `spikes_o`, `slot_valid_o` and `done_o` are all zero.
- R2: Channel i takes its intensity from `values_i[i*VAL_W +: VAL_W]`. It emits exactly round(SPIKE_BUDGET·v_i / Σv) spikes in a window, and an exact half rounds up.
- R3: The spike count of a channel is clamped to NUM_SLOTS.
- R4: If every intensity is zero, no spike is emitted, no division is performed, and the window still runs in full and ends with done.
- R5: A window is exactly NUM_SLOTS consecutive cycles with `slot_valid_o` high.
- R6: For a load with a nonzero sum, `slot_valid_o` stays low for at least one cycle of setup before the first slot. `spikes_o` is zero in every cycle in which `slot_valid_o` is low.
- R7: `done_o` is high for exactly one cycle: the cycle right after the last slot.
- R8: A load strobe arriving while a setup or a window is in progress (including the done cycle) is ignored. It changes neither the current spike counts nor starts a further window.
- R9: Spikes are scattered over the window. A channel with fewer spikes than half the slots does not have all of them in its leading slots.
- R10: Each channel draws from its own nonzero pseudo-random sequence, so two channels with equal counts produce different slot patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Start strobe, accepted only while idle |
| values_i | input | NUM_CH*VAL_W | Packed channel intensities, channel 0 in the low bits |
| spikes_o | output | NUM_CH | One spike bit per channel for the current slot |
| slot_valid_o | output | 1 | High in each of the NUM_SLOTS window cycles |
| done_o | output | 1 | One-cycle pulse after the last slot |

## Verification
The assertions take for granted that `values_i` is stable in any cycle in which `load_i` is high while the block is idle. They also take for granted that the parameters satisfy NUM_SLOTS ≥ 1 and SPIKE_BUDGET ≥ 1. The bench drives a new vector and the strobe together on the falling edge and holds both for one full cycle. It also strobes load in the middle of a window with a different vector, which checks that the inputs are ignored there rather than assumed quiet. The sweep covers zero sums, exact-half rounding, clamping and a set of arithmetically generated vectors on a reduced configuration.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } enc_state_t;
endpackage

// File: rtl/spk_divider.sv
// Restoring divider, one quotient bit per cycle.
module spk_divider #(
  parameter int NUM_W = 21,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quot_o,
  output logic             done_o
);
  localparam int IT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] dvd_q, dvd_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [IT_W-1:0]  it_q, it_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic [DEN_W:0]   shifted;

  always_comb begin
    dvd_d   = dvd_q;
    rem_d   = rem_q;
    den_d   = den_q;
    it_d    = it_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    shifted = {rem_q, dvd_q[NUM_W-1]};
    if (start_i) begin
      dvd_d  = num_i;
      rem_d  = '0;
      den_d  = den_i;
      it_d   = IT_W'(NUM_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (shifted >= {1'b0, den_q}) begin
        rem_d = DEN_W'(shifted - {1'b0, den_q});
        dvd_d = {dvd_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = shifted[DEN_W-1:0];
        dvd_d = {dvd_q[NUM_W-2:0], 1'b0};
      end
      it_d = it_q - 1'b1;
      if (it_q == IT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dvd_q  <= dvd_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      it_q   <= it_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign quot_o = dvd_q;
  assign done_o = done_q;

  // R4: a division is never started with a zero divisor
  assert_nonzero_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (den_i != '0));
  // R2: a start is never issued while a division is still running
  assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_i);
endmodule

// File: rtl/spk_channel.sv
// One channel: remaining-spike counter plus selection-sampling decision.
module spk_channel #(
  parameter int          CNT_W = 8,
  parameter logic [15:0] SEED  = 16'h0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] slots_left_i,
  output logic             spike_o
);
  localparam int RND_W = 16;

  logic [RND_W-1:0]       lfsr_q, lfsr_d;
  logic [CNT_W-1:0]       left_q, left_d;
  logic [RND_W+CNT_W-1:0] prod;
  logic [CNT_W-1:0]       scaled;
  logic                   fire;

  always_comb begin
    prod   = {{CNT_W{1'b0}}, lfsr_q} * {{RND_W{1'b0}}, slots_left_i};
    scaled = prod[RND_W +: CNT_W];
    fire   = step_i && (scaled < left_q);
    left_d = left_q;
    lfsr_d = lfsr_q;
    if (clear_i)     left_d = '0;
    else if (load_i) left_d = cnt_i;
    else if (fire)   left_d = left_q - 1'b1;
    if (step_i)
      lfsr_d = {lfsr_q[RND_W-2:0], lfsr_q[15] ^ lfsr_q[14] ^ lfsr_q[12] ^ lfsr_q[3]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      left_q <= '0;
    end else begin
      lfsr_q <= lfsr_d;
      left_q <= left_d;
    end
  end

  assign spike_o = fire;

  // R3: the remaining spikes always fit into the remaining slots
  assert_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (left_q <= slots_left_i));
  // R2: every allotted spike has been emitted after the last slot
  assert_all_emitted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && slots_left_i == CNT_W'(1)) |=> (left_q == '0));
  // R10: the generator never locks up at zero
  assert_lfsr_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/spike_train_encoder.sv
module spike_train_encoder #(
  parameter int NUM_CH       = 4,
  parameter int VAL_W        = 8,
  parameter int NUM_SLOTS    = 128,
  parameter int SPIKE_BUDGET = 2000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [NUM_CH*VAL_W-1:0] values_i,
  output logic [NUM_CH-1:0]       spikes_o,
  output logic                    slot_valid_o,
  output logic                    done_o
);
  import spk_pkg::*;

  localparam int SUM_W = VAL_W + $clog2(NUM_CH) + 1;
  localparam int DEN_W = SUM_W + 1;
  localparam int BUD_W = $clog2(SPIKE_BUDGET + 1);
  localparam int NUM_W = BUD_W + VAL_W + 2;
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  enc_state_t              state_q, state_d;
  logic [IDX_W-1:0]        ch_q, ch_d;
  logic [CNT_W-1:0]        slot_q, slot_d;
  logic [NUM_CH*VAL_W-1:0] vals_q, vals_d;
  logic [SUM_W-1:0]        sum_q, sum_d, in_sum;
  logic                    go_q, go_d, clr;
  logic [NUM_W-1:0]        num, quot;
  logic [CNT_W-1:0]        cnt_clamped, slots_left;
  logic                    div_done, running;

  always_comb begin
    in_sum = '0;
    for (int i = 0; i < NUM_CH; i++)
      in_sum = in_sum + SUM_W'(values_i[i*VAL_W +: VAL_W]);
  end

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    slot_d  = slot_q;
    vals_d  = vals_q;
    sum_d   = sum_q;
    go_d    = 1'b0;
    clr     = 1'b0;
    case (state_q)
      ST_IDLE: if (load_i) begin
        vals_d = values_i;
        sum_d  = in_sum;
        clr    = 1'b1;
        ch_d   = '0;
        slot_d = '0;
        if (in_sum == '0) state_d = ST_RUN;
        else begin
          state_d = ST_DIV;
          go_d    = 1'b1;
        end
      end
      ST_DIV: if (div_done) begin
        if (ch_q == IDX_W'(NUM_CH - 1)) state_d = ST_RUN;
        else begin
          ch_d = ch_q + 1'b1;
          go_d = 1'b1;
        end
      end
      ST_RUN: begin
        slot_d = slot_q + 1'b1;
        if (slot_q == CNT_W'(NUM_SLOTS - 1)) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      slot_q  <= '0;
      vals_q  <= '0;
      sum_q   <= '0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      slot_q  <= slot_d;
      vals_q  <= vals_d;
      sum_q   <= sum_d;
      go_q    <= go_d;
    end
  end

  // Rounded share: (2*budget*v + sum) / (2*sum)
  assign num = ((NUM_W'(SPIKE_BUDGET) * NUM_W'(vals_q[ch_q*VAL_W +: VAL_W])) << 1)
             + NUM_W'(sum_q);

  spk_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (go_q),
    .num_i   (num),
    .den_i   ({sum_q, 1'b0}),
    .quot_o  (quot),
    .done_o  (div_done)
  );

  assign cnt_clamped = (quot > NUM_W'(NUM_SLOTS)) ? CNT_W'(NUM_SLOTS) : CNT_W'(quot);
  assign running     = (state_q == ST_RUN);
  assign slots_left  = CNT_W'(NUM_SLOTS) - slot_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [15:0] CH_SEED = 16'((32'h0000ACE1 ^ (32'h9E37 * (g + 1))) | 32'h1);
    spk_channel #(.CNT_W(CNT_W), .SEED(CH_SEED)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (clr),
      .load_i       (div_done && (state_q == ST_DIV) && (ch_q == IDX_W'(g))),
      .cnt_i        (cnt_clamped),
      .step_i       (running),
      .slots_left_i (slots_left),
      .spike_o      (spikes_o[g])
    );
  end

  assign slot_valid_o = running;
  assign done_o       = (state_q == ST_DONE);

  // R6: no spike outside a slot
  assert_spike_in_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spikes_o != '0) |-> slot_valid_o);
  // R7: done follows the last slot and lasts one cycle
  assert_done_after_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slot_valid_o) |-> done_o);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: a load while busy leaves the captured vector alone
  assert_busy_load_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && load_i) |=> $stable(vals_q));
endmodule

// File: tb/spike_train_encoder_test.sv
module spike_train_encoder_test;
  localparam int NCH = 4;
  localparam int VW  = 8;
  localparam int NT  = 64;
  localparam int NS  = 200;

  logic              clk, rst_n, load;
  logic [NCH*VW-1:0] vals;
  logic [NCH-1:0]    spikes;
  logic              sv, done;

  int checks = 0;
  int fails  = 0;

  spike_train_encoder #(.NUM_CH(NCH), .VAL_W(VW), .NUM_SLOTS(NT), .SPIKE_BUDGET(NS)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load), .values_i(vals),
    .spikes_o(spikes), .slot_valid_o(sv), .done_o(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_cnt(input logic [NCH*VW-1:0] v, input int c);
    int sum = 0;
    int n;
    for (int i = 0; i < NCH; i++) sum += int'(v[i*VW +: VW]);
    if (sum == 0) return 0;
    n = (2 * NS * int'(v[c*VW +: VW]) + sum) / (2 * sum);
    return (n > NT) ? NT : n;
  endfunction

  task automatic run_window(input logic [NCH*VW-1:0] v, input bit mid_load);
    int cnt [NCH];
    logic [NT-1:0] pat [NCH];
    int slots = 0, setup = 0, guard = 0, exp_n;
    bit prev_sv = 0, seen_done = 0, stray = 0, zero_sum;
    zero_sum = (v == '0);
    for (int c = 0; c < NCH; c++) begin cnt[c] = 0; pat[c] = '0; end
    @(negedge clk);
    vals = v; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    while (!seen_done && guard < 2000) begin
      guard++;
      if (sv) begin
        for (int c = 0; c < NCH; c++) begin
          cnt[c] += int'(spikes[c]);
          pat[c][slots] = spikes[c];
        end
        slots++;
      end else begin
        if (slots == 0) setup++;
        if (spikes != '0) stray = 1;
      end
      if (done) begin
        seen_done = 1;
        check(prev_sv && !sv && slots == NT, "R7 done right after last slot", slots, NT);
      end
      prev_sv = sv;
      if (mid_load && slots == 10 && sv) begin
        vals = ~v; load = 1'b1;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
    end
    load = 1'b0;
    check(seen_done, "R7 done seen", int'(seen_done), 1);
    check(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
    check(slots == NT, "R5 window length", slots, NT);
    check(!stray, "R6 no spike outside slot", int'(stray), 0);
    if (!zero_sum) check(setup >= 1, "R6 setup phase before slot 0", setup, 1);
    for (int c = 0; c < NCH; c++) begin
      exp_n = expect_cnt(v, c);
      check(cnt[c] == exp_n, zero_sum ? "R4 zero input count" :
            (exp_n == NT ? "R3 clamped count" : "R2 spike count"), cnt[c], exp_n);
      if (exp_n >= 4 && exp_n <= NT / 2)
        check((pat[c] >> exp_n) != '0, "R9 spikes scattered", exp_n, exp_n);
    end
    if (expect_cnt(v, 0) == expect_cnt(v, 1) && expect_cnt(v, 0) > 0 && expect_cnt(v, 0) < NT)
      check(pat[0] != pat[1], "R10 channels differ", 0, 1);
    if (mid_load) begin
      bit restarted = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (sv) restarted = 1;
      end
      check(!restarted, "R8 busy load ignored", int'(restarted), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; vals = '0;
    repeat (3) @(negedge clk);
    check(spikes == '0 && !sv && !done, "R1 reset outputs", int'({spikes, sv, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(spikes == '0 && !sv && !done, "R1 after reset", int'({spikes, sv, done}), 0);

    run_window('0, 1'b0);                             // R4 all zero
    run_window({8'd0, 8'd0, 8'd0, 8'd255}, 1'b0);     // R3 single channel
    run_window({8'd1, 8'd1, 8'd1, 8'd1}, 1'b0);       // R2, R10 equal shares
    run_window({8'd7, 8'd5, 8'd3, 8'd1}, 1'b0);       // R2 half rounds up, R3 clamp
    run_window({8'd0, 8'd0, 8'd15, 8'd1}, 1'b0);      // R2 12.5 -> 13
    run_window({8'd255, 8'd255, 8'd255, 8'd255}, 1'b0);
    run_window({8'd200, 8'd90, 8'd60, 8'd60}, 1'b1);  // R8 mid-window load
    for (int k = 0; k < 16; k++) begin
      logic [NCH*VW-1:0] v;
      for (int c = 0; c < NCH; c++)
        v[c*VW +: VW] = VW'((k * 37 + c * 91 + k * c * 13) % 256);
      run_window(v, (k % 5) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule